// File: doc/BRIEF.md
# Paged Burst Controller for an Asynchronous Byte-Wide Static RAM

This block sits on the synchronous side of a chip and runs an external asynchronous static RAM of 262,144 bytes. The RAM has an 18-bit address, an 8-bit bidirectional data bus, an active-low and an active-high select, an active-low write strobe and an active-low output enable. A host issues one request at a time: a start address, a direction, and a burst length. The controller then runs one memory cycle per byte, with cycle widths taken from clock-count parameters.

The memory is arranged as pages of 16 bytes, where the upper 14 address bits pick the page. Inside a page the controller keeps the chip selected and changes only the low four address bits from beat to beat. When a burst reaches the end of a page, the controller deselects the device for one clock and then carries on in the next page. Between requests the device is always left deselected, so it falls into its low-power standby state. Write bytes are pulled from the host one at a time through a take strobe. Each read byte comes back with a one-clock valid pulse.

The direction of the data bus is always turned with at least one clock of gap. The controller stops driving before output enable goes low, and output enable is high again before the controller drives.

Top module: `sram_page_ctrl`

## Requirements
- R1: Out of reset and whenever `reqReady` is high, the memory side is idle: `memCe1N`=1, `memCe2`=0, `memWeN`=1, `memOeN`=1, and the controller does not drive `memDq`.
- R2: After the last beat of every request the device is deselected (standby) before `reqReady` is seen high again.
- R3: A write beat lasts CYCLE_CLKS clocks with the device selected. `memWeN` is low for the first CYCLE_CLKS-1 clocks and high in the last clock. Write data is driven for the whole beat, and `memOeN` stays high whenever `memWeN` is low.
- R4: A read beat lasts max(CYCLE_CLKS, OE_CLKS) clocks with `memWeN` high and `memOeN` low. A read burst of n beats holds `memOeN` low for exactly n times that count.
- R5: The two sides never drive the data bus together. The controller never drives in a clock where `memOeN` is low or was low in the clock before. `memOeN` never goes low in a clock where the controller drives or drove in the clock before.
- R6: While the device stays selected from one clock to the next, address bits 17..4 do not change.
- R7: A burst that crosses a 16-byte page boundary deselects the device for exactly one clock at each crossing. The burst then continues at the first byte of the next page.
- R8: `reqLen`=n gives n+1 beats at successive addresses starting from `reqAddr`. The address wraps from 0x3FFFF to 0.
- R9: Each read byte is returned on `rdData` with a single-clock `rdValid` pulse, in address order, one clock after its beat ends.
- R10: `wrTake` is high once for each write byte. The `reqWdata` value present at that clock edge is written to the next address of the burst.
- R11: `reqReady` is high only when no request is in progress. A request is accepted only in a clock where `reqValid` and `reqReady` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write burst, 0 = read burst |
| reqAddr | input | 18 | Start byte address |
| reqWdata | input | 8 | Current write byte, sampled when `wrTake` is high |
| reqLen | input | 8 | Number of beats minus one |
| reqReady | output | 1 | Controller idle and able to accept a request |
| wrTake | output | 1 | `reqWdata` is consumed at this clock edge |
| rdData | output | 8 | Returned read byte |
| rdValid | output | 1 | One-clock pulse marking a valid `rdData` |
| memCe1N | output | 1 | Active-low device select |
| memCe2 | output | 1 | Active-high device select |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output enable |
| memAddr | output | 18 | Memory address |
| memDq | inout | 8 | Bidirectional memory data bus |

## Verification
The bound checker watches the memory-side handshake in every clock. It checks the idle state while ready, the select pair moving together, output enable held high under a write strobe, and the one-clock gap on each bus turnaround in both directions. It also checks that the page bits hold while the device stays selected and that read-valid pulses never run back to back. Some behaviour can only be shown by the bench's scenarios against a behavioural memory: that bytes written reach the right addresses, and that they read back in order across a page crossing and across the top-of-memory wrap. The same holds for the count of standby clocks inside a crossing burst, the exact strobe widths, and the write-take handshake.

// File: rtl/sram_page_pkg.sv
package sram_page_pkg;

  // strobes from the sequencer into the datapath registers
  typedef struct packed {
    logic loadReq;   // latch start address and first write byte
    logic stepAddr;  // advance to the next byte address
    logic loadWd;    // latch the next write byte
    logic capture;   // sample the memory bus into the read register
  } dpStrobe_t;

  // memory-side levels for the current clock
  typedef struct packed {
    logic select;
    logic writeLow;
    logic outEnLow;
    logic drive;
  } busCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_GAP  = 2'd2
  } ctlState_t;

endpackage

// File: rtl/sram_page_fsm.sv
module sram_page_fsm
  import sram_page_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int CYCLE_CLKS = 3,
  parameter int OE_CLKS    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             pageEnd,
  output logic             reqReady,
  output logic             wrTake,
  output dpStrobe_t        strobe,
  output busCtl_t          busCtl
);

  localparam int READ_CLKS = (CYCLE_CLKS > OE_CLKS) ? CYCLE_CLKS : OE_CLKS;
  localparam int CNT_W     = $clog2(READ_CLKS + 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(CYCLE_CLKS - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(READ_CLKS - 1);

  ctlState_t        state, nextState;
  logic [CNT_W-1:0] beatCnt;
  logic [LEN_W-1:0] remain;
  logic             isWrite;
  logic             beatLast;

  assign beatLast = isWrite ? (beatCnt == WR_LAST) : (beatCnt == RD_LAST);

  always_comb begin
    strobe    = '0;
    busCtl    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          nextState      = ST_BEAT;
        end
      end
      ST_BEAT: begin
        busCtl.select = 1'b1;
        if (isWrite) begin
          busCtl.drive    = 1'b1;
          busCtl.writeLow = (beatCnt < WR_LAST);
        end else begin
          busCtl.outEnLow = 1'b1;
        end
        if (beatLast) begin
          strobe.capture = !isWrite;
          if (remain == '0) begin
            nextState = ST_IDLE;
          end else begin
            strobe.stepAddr = 1'b1;
            strobe.loadWd   = isWrite;
            nextState       = pageEnd ? ST_GAP : ST_BEAT;
          end
        end
      end
      ST_GAP:  nextState = ST_BEAT;
      default: nextState = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign wrTake   = (strobe.loadReq & reqWrite) | strobe.loadWd;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
      remain  <= '0;
      isWrite <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_BEAT && !beatLast) beatCnt <= beatCnt + 1'b1;
      else                               beatCnt <= '0;
      if (strobe.loadReq) begin
        remain  <= reqLen;
        isWrite <= reqWrite;
      end else if (strobe.stepAddr) begin
        remain <= remain - 1'b1;
      end
    end
  end

endmodule

// File: rtl/sram_page_dp.sv
module sram_page_dp
  import sram_page_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  busCtl_t           busCtl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              pageEnd,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdReg;
  logic [DATA_W-1:0] rdReg;
  logic              rdValidReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg    <= '0;
      wdReg      <= '0;
      rdReg      <= '0;
      rdValidReg <= 1'b0;
    end else begin
      if (strobe.loadReq)       addrReg <= reqAddr;
      else if (strobe.stepAddr) addrReg <= addrReg + 1'b1;
      if (strobe.loadReq || strobe.loadWd) wdReg <= reqWdata;
      if (strobe.capture) rdReg <= memDqIn;
      rdValidReg <= strobe.capture;
    end
  end

  assign pageEnd = &addrReg[PAGE_W-1:0];
  assign memCe1N = !busCtl.select;
  assign memCe2  = busCtl.select;
  assign memWeN  = !busCtl.writeLow;
  assign memOeN  = !busCtl.outEnLow;
  assign memAddr = addrReg;
  assign dqOut   = wdReg;
  assign dqOe    = busCtl.drive;
  assign rdData  = rdReg;
  assign rdValid = rdValidReg;

endmodule

// File: rtl/sram_page_ctrl.sv
module sram_page_ctrl
  import sram_page_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 4,
  parameter int LEN_W      = 8,
  parameter int CYCLE_CLKS = 3,
  parameter int OE_CLKS    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              reqReady,
  output logic              wrTake,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memDq
);

  dpStrobe_t         strobe;
  busCtl_t           busCtl;
  logic              pageEnd;
  logic              dqOe;
  logic [DATA_W-1:0] dqOut;

  sram_page_fsm #(
    .LEN_W(LEN_W), .CYCLE_CLKS(CYCLE_CLKS), .OE_CLKS(OE_CLKS)
  ) u_fsm (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLen(reqLen), .pageEnd(pageEnd), .reqReady(reqReady),
    .wrTake(wrTake), .strobe(strobe), .busCtl(busCtl)
  );

  sram_page_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .busCtl(busCtl),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .memDqIn(memDq),
    .pageEnd(pageEnd), .memCe1N(memCe1N), .memCe2(memCe2),
    .memWeN(memWeN), .memOeN(memOeN), .memAddr(memAddr),
    .dqOut(dqOut), .dqOe(dqOe), .rdData(rdData), .rdValid(rdValid)
  );

  assign memDq = dqOe ? dqOut : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_page_chk.sv
module sram_page_chk #(
  parameter int ADDR_W = 18,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              rdValid,
  input logic              memCe1N,
  input logic              memCe2,
  input logic              memWeN,
  input logic              memOeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              dqOe
);

  p_idle_standby_r1: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (memCe1N && !memCe2 && memWeN && memOeN && !dqOe));

  // the two selects must always agree (R2 standby is entered by both)
  p_select_pair_r2: assert property (@(posedge clk) disable iff (rst)
    memCe1N == !memCe2);

  p_we_blocks_oe_r3: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> (memOeN && dqOe && !memCe1N));

  p_drive_after_oe_r5: assert property (@(posedge clk) disable iff (rst)
    dqOe |-> (memOeN && $past(memOeN)));

  p_oe_after_drive_r5: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> (!dqOe && !$past(dqOe)));

  p_page_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!memCe1N && $past(!memCe1N)) |->
      (memAddr[ADDR_W-1:PAGE_W] == $past(memAddr[ADDR_W-1:PAGE_W])));

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

endmodule

bind sram_page_ctrl sram_page_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .reqReady(reqReady), .rdValid(rdValid),
  .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN),
  .memAddr(memAddr), .dqOe(dqOe)
);

// File: tb/sram_page_ctrl_test.sv
module sram_page_ctrl_test;

  localparam int CYCLE_CLKS = 3;
  localparam int OE_CLKS    = 2;
  localparam int READ_CLKS  = (CYCLE_CLKS > OE_CLKS) ? CYCLE_CLKS : OE_CLKS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [7:0]  reqLen = '0;
  logic        reqReady, wrTake, rdValid;
  logic [7:0]  rdData;
  logic        memCe1N, memCe2, memWeN, memOeN;
  logic [17:0] memAddr;
  wire  [7:0]  memDq;

  always #10 clk = !clk;

  sram_page_ctrl #(.CYCLE_CLKS(CYCLE_CLKS), .OE_CLKS(OE_CLKS)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqLen(reqLen),
    .reqReady(reqReady), .wrTake(wrTake), .rdData(rdData), .rdValid(rdValid),
    .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN),
    .memAddr(memAddr), .memDq(memDq)
  );

  // behavioural memory, aliased on the low 10 address bits
  logic [7:0] memArr [0:1023];
  logic       modelEn;
  assign modelEn = !memCe1N && memCe2 && memWeN && !memOeN;
  assign memDq   = modelEn ? memArr[memAddr[9:0]] : 8'bz;

  always @(posedge memWeN)
    if (!memCe1N && memCe2) memArr[memAddr[9:0]] = memDq;

  int checks = 0;
  int errors = 0;
  logic [7:0]  shadow [0:1023];
  logic [7:0]  rdQ[$];
  logic [25:0] wrQ[$];
  int gapCnt = 0;
  int oeCnt  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: memory-side protocol and scoreboard pops
  logic prevSel = 1'b0;
  logic prevWe  = 1'b1;
  int   weRun   = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prevSel && !(!memCe1N && memCe2) && !reqReady) gapCnt++;
      if (!memOeN) oeCnt++;
      if (modelEn && memDq !== memArr[memAddr[9:0]])
        check(1'b0, "R5 bus contention on read", int'(memDq), int'(memArr[memAddr[9:0]]));
      if (!memWeN) begin
        weRun++;
        check(memOeN === 1'b1 && !$isunknown(memDq), "R3 oe high and data driven under write strobe",
              int'(memOeN), 1);
      end
      if (!prevWe && memWeN) begin
        check(weRun == CYCLE_CLKS - 1, "R3 write strobe width", weRun, CYCLE_CLKS - 1);
        if (wrQ.size() == 0) check(1'b0, "R10 unexpected write", int'(memAddr), 0);
        else begin
          logic [25:0] e;
          e = wrQ.pop_front();
          check({memAddr, memDq} == e, "R8 R10 write address and byte",
                int'({memAddr, memDq}), int'(e));
        end
        weRun = 0;
      end
      if (rdValid) begin
        if (rdQ.size() == 0) check(1'b0, "R9 unexpected read valid", int'(rdData), 0);
        else begin
          logic [7:0] e;
          e = rdQ.pop_front();
          check(rdData == e, "R9 read byte", int'(rdData), int'(e));
        end
      end
      prevSel = !memCe1N && memCe2;
      prevWe  = memWeN;
    end
  end

  function automatic logic [7:0] byteOf(input int k, input logic [7:0] seed);
    return seed + 8'(k * 37) ^ 8'(k << 3);
  endfunction

  task automatic checkEnd(input logic [17:0] a, input int n);
    int expGap;
    expGap = (int'(a[3:0]) + n - 1) / 16;
    check(memCe1N === 1'b1 && memCe2 === 1'b0, "R2 standby after request", int'(memCe1N), 1);
    check(gapCnt == expGap, "R7 page crossing gaps", gapCnt, expGap);
  endtask

  task automatic doWrite(input logic [17:0] a, input int n, input logic [7:0] seed);
    int k;
    k = 0;
    @(negedge clk);
    gapCnt = 0;
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqLen = 8'(n - 1);
    reqWdata = byteOf(0, seed);
    while (k < n) begin
      #1;
      if (wrTake) begin
        wrQ.push_back({18'(a + 18'(k)), reqWdata});
        shadow[10'(a + 18'(k))] = reqWdata;
        @(posedge clk);
        k++;
        @(negedge clk);
        if (k == 1) check(reqReady == 1'b0, "R11 ready low during burst", int'(reqReady), 0);
        reqValid = 1'b0;
        if (k < n) reqWdata = byteOf(k, seed);
      end else begin
        @(negedge clk);
      end
    end
    while (!reqReady) @(negedge clk);
    checkEnd(a, n);
    check(wrQ.size() == 0, "R10 all bytes written", wrQ.size(), 0);
  endtask

  task automatic doRead(input logic [17:0] a, input int n);
    @(negedge clk);
    gapCnt = 0; oeCnt = 0;
    for (int k = 0; k < n; k++) rdQ.push_back(shadow[10'(a + 18'(k))]);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqLen = 8'(n - 1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R11 ready low during read", int'(reqReady), 0);
    while (!(reqReady && rdQ.size() == 0)) @(negedge clk);
    checkEnd(a, n);
    check(oeCnt == n * READ_CLKS, "R4 output enable clocks", oeCnt, n * READ_CLKS);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      memArr[i] = 8'h00;
      shadow[i] = 8'h00;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 idle state after reset
    check(reqReady === 1'b1 && memCe1N === 1'b1 && memCe2 === 1'b0 &&
          memWeN === 1'b1 && memOeN === 1'b1 && memDq === 8'bz,
          "R1 reset idle", int'({reqReady, memCe1N, memCe2, memWeN, memOeN}), 5'b11011);
    // R1 ignored while nothing is requested: no take strobe
    check(wrTake === 1'b0, "R11 no take without request", int'(wrTake), 0);

    doWrite(18'h12340, 4, 8'h11);    // in-page write
    doRead (18'h12340, 4);           // in-page read right after write
    doWrite(18'h00355, 1, 8'h5A);    // single beat
    doRead (18'h00355, 1);
    doWrite(18'h1557C, 6, 8'hA3);    // R7 crosses one page
    doRead (18'h1557C, 6);
    doWrite(18'h3FFFE, 4, 8'h3C);    // R8 wraps at top of memory
    doRead (18'h3FFFE, 4);
    doWrite(18'h00200, 20, 8'h77);   // long burst, one crossing
    doRead (18'h00200, 20);
    doRead (18'h12341, 2);           // read then write back-to-back
    doWrite(18'h12342, 2, 8'hE1);
    doRead (18'h12340, 4);
    doWrite(18'h004F0, 33, 8'h09);   // three pages
    doRead (18'h004F0, 33);

    repeat (5) @(negedge clk);
    check(rdQ.size() == 0 && wrQ.size() == 0, "R9 scoreboard drained", rdQ.size(), 0);
    finishRun();
  end

endmodule